// File: doc/BRIEF.md
# Fault Event Capture Front-End

This block watches for a fault condition on behalf of a PWM timer and turns it into a latched flag and an interrupt request. The fault can come from one of two places. One is an external fault pad. The other is the output of an on-chip comparator. A select input picks the source, and only the chosen signal reaches the capture logic. Whichever source is chosen, it passes through the same path: a two-stage synchronizer, an optional noise filter and a programmable edge detector.

A qualifying edge sets a sticky fault flag. The flag can be cleared in two ways. Software writes a one to it, and the clear lands one cycle after the write. Hardware clears it when the interrupt controller pulses its acknowledge. The interrupt request is raised only while the flag, the local fault-interrupt enable and the global interrupt enable are all set. The pad is read from its input buffer, so a fault is still seen when the pad is driven as an output.

Top module: `fault_capture`

## Requirements
- R1: With `src_cmp_i`=0 the pad feeds the capture path, and comparator activity never sets the flag.
- R2: With `src_cmp_i`=1 the comparator output feeds the capture path, including the filter and the edge selector, and pad activity never sets the flag.
- R3: With the filter off, an input change applied before clock edge 1 sets `fault_flag_o` after edge 3 and not earlier. This covers two synchronizer stages plus the flag register.
- R4: With `filt_en_i`=1, the filtered level follows the input only after four consecutive synchronized samples that differ from it. A held change therefore sets the flag after edge 7, and a pulse lasting three cycles never sets it.
- R5: `edge_rise_i`=1 selects rising edges and `edge_rise_i`=0 selects falling edges. The opposite edge does not set the flag.
- R6: Once set, the flag stays set until it is cleared by software or by an acknowledge.
- R7: A cycle with `flag_wr_i`=1 and `flag_wdata_i`=1 clears the flag at the second clock edge after the write is sampled. The flag is still set after the first edge.
- R8: A write with `flag_wdata_i`=0 leaves the flag unchanged.
- R9: `int_ack_i`=1 sampled at an edge clears the flag at that edge.
- R10: When a qualifying edge meets a pending software clear or an acknowledge in the same cycle, the flag ends set.
- R11: `irq_o` is 1 exactly when `gie_i`, `fault_ie_i` and `fault_flag_o` are all 1.
- R12: After reset, `fault_flag_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fault_pin_i | input | 1 | Fault pad input buffer value |
| cmp_out_i | input | 1 | Comparator output |
| src_cmp_i | input | 1 | Source select: 1 comparator, 0 pad |
| filt_en_i | input | 1 | Noise filter enable |
| edge_rise_i | input | 1 | Edge select: 1 rising, 0 falling |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data (1 clears) |
| int_ack_i | input | 1 | Interrupt acknowledge pulse |
| gie_i | input | 1 | Global interrupt enable |
| fault_ie_i | input | 1 | Fault interrupt enable |
| fault_flag_o | output | 1 | Sticky fault flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures the exact cycle in which the flag rises, both with and without the filter. A design whose latency is off by one stage, or whose filter counts three or five samples, fails those checks. It also sends a three-cycle glitch through the filter, which a filter that does not reset its count on a returning sample would wrongly accept. An edge is driven into the same cycle as a delayed software clear, and again into the same cycle as an acknowledge. A design that gives the clear priority would lose that fault. Finally, the unselected source and the opposite edge are toggled, which catches a mux or edge selector that leaks.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;
  typedef enum logic {SRC_PIN = 1'b0, SRC_CMP = 1'b1} fault_src_e;
  typedef enum logic {EDGE_FALL = 1'b0, EDGE_RISE = 1'b1} fault_edge_e;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic dout_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_d = din_i;
    end else begin : g_many
      always_comb sr_d = {sr_q[STAGES-2:0], din_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign dout_o = sr_q[STAGES-1];
endmodule

// File: rtl/fault_filter.sv
module fault_filter #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic din_i,
  output logic dout_o
);
  localparam int CNT_W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      lvl_d = din_i;
      cnt_d = '0;
    end else if (din_i == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      lvl_d = din_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign dout_o = en_i ? lvl_q : din_i;

  assert_filter_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q != LAST) |=> $stable(lvl_q));
  assert_filter_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && din_i == lvl_q) |=> (cnt_q == '0));
endmodule

// File: rtl/fault_edge.sv
module fault_edge
  import fault_capture_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    rise  = lvl_i & ~prev_q;
    fall  = ~lvl_i & prev_q;
    hit_o = (fault_edge_e'(rise_sel_i) == EDGE_RISE) ? rise : fall;
  end

  assert_edge_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> (prev_q == rise_sel_i));
endmodule

// File: rtl/fault_capture.sv
module fault_capture
  import fault_capture_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_pin_i,
  input  logic cmp_out_i,
  input  logic src_cmp_i,
  input  logic filt_en_i,
  input  logic edge_rise_i,
  input  logic flag_wr_i,
  input  logic flag_wdata_i,
  input  logic int_ack_i,
  input  logic gie_i,
  input  logic fault_ie_i,
  output logic fault_flag_o,
  output logic irq_o
);
  logic src_lvl, sync_lvl, filt_lvl, edge_hit;
  logic clr_pend_q, clr_pend_d;
  logic flag_q, flag_d;

  always_comb src_lvl = (fault_src_e'(src_cmp_i) == SRC_CMP) ? cmp_out_i : fault_pin_i;

  fault_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(src_lvl), .dout_o(sync_lvl));

  fault_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(filt_en_i), .din_i(sync_lvl), .dout_o(filt_lvl));

  fault_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(filt_lvl), .rise_sel_i(edge_rise_i), .hit_o(edge_hit));

  always_comb begin
    clr_pend_d = flag_wr_i & flag_wdata_i;
    flag_d     = flag_q;
    if (edge_hit)                     flag_d = 1'b1;
    else if (clr_pend_q || int_ack_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_pend_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      clr_pend_q <= clr_pend_d;
      flag_q     <= flag_d;
    end
  end

  assign fault_flag_o = flag_q;
  assign irq_o        = gie_i & fault_ie_i & flag_q;

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_flag_o && !clr_pend_q && !int_ack_i) |=> fault_flag_o);
  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ack_i && !edge_hit) |=> !fault_flag_o);
  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_hit |=> fault_flag_o);
  assert_clear_pending_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_pend_q && !edge_hit) |=> !fault_flag_o);
  assert_zero_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr_i && !flag_wdata_i && !int_ack_i && !edge_hit && !clr_pend_q && fault_flag_o)
      |=> fault_flag_o);
endmodule

// File: tb/fault_capture_tb.sv
`timescale 1ns/1ps
module fault_capture_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, cmp = 1'b0, sel = 1'b0, filt = 1'b0, rise = 1'b1;
  logic wr = 1'b0, wdata = 1'b0, ack = 1'b0, gie = 1'b0, fie = 1'b0;
  logic flag, irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fault_capture u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fault_pin_i(pin), .cmp_out_i(cmp),
    .src_cmp_i(sel), .filt_en_i(filt), .edge_rise_i(rise), .flag_wr_i(wr),
    .flag_wdata_i(wdata), .int_ack_i(ack), .gie_i(gie), .fault_ie_i(fie),
    .fault_flag_o(flag), .irq_o(irq));

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic sw_clear();
    wr = 1'b1; wdata = 1'b1;
    tick(1);
    wr = 1'b0; wdata = 1'b0;
    tick(2);
  endtask

  task automatic pulse_pin_set();
    pin = 1'b1; tick(4);
    pin = 1'b0; tick(4);
  endtask

  task automatic t_reset();
    check("R12", "flag after reset", flag, 1'b0);
    check("R12", "irq after reset", irq, 1'b0);
  endtask

  task automatic t_pin_latency();
    cmp = 1'b1; tick(6);
    check("R1", "comparator ignored with pad selected", flag, 1'b0);
    cmp = 1'b0; tick(4);
    pin = 1'b1;
    tick(2);
    check("R3", "flag after edge 2", flag, 1'b0);
    tick(1);
    check("R3", "flag after edge 3", flag, 1'b1);
    pin = 1'b0; tick(3);
  endtask

  task automatic t_sticky_clear();
    tick(8);
    check("R6", "flag held", flag, 1'b1);
    wr = 1'b1; wdata = 1'b0; tick(1); wr = 1'b0; tick(3);
    check("R8", "zero write ignored", flag, 1'b1);
    wr = 1'b1; wdata = 1'b1; tick(1);
    wr = 1'b0; wdata = 1'b0;
    check("R7", "flag one edge after clear write", flag, 1'b1);
    tick(1);
    check("R7", "flag two edges after clear write", flag, 1'b0);
  endtask

  task automatic t_ack();
    pulse_pin_set();
    check("R9", "flag set before ack", flag, 1'b1);
    ack = 1'b1; tick(1); ack = 1'b0;
    check("R9", "flag cleared by ack", flag, 1'b0);
  endtask

  task automatic t_irq();
    pulse_pin_set();
    for (int g = 0; g < 2; g++) begin
      for (int l = 0; l < 2; l++) begin
        gie = g[0]; fie = l[0]; #1;
        check("R11", "irq with flag set", irq, g[0] & l[0]);
      end
    end
    sw_clear();
    check("R11", "irq with flag clear", irq, 1'b0);
    gie = 1'b0; fie = 1'b0;
  endtask

  task automatic t_cmp_source();
    sel = 1'b1; tick(4);
    pin = 1'b1; tick(6);
    check("R2", "pad ignored with comparator selected", flag, 1'b0);
    pin = 1'b0; tick(4);
    cmp = 1'b1;
    tick(2);
    check("R2", "comparator flag after edge 2", flag, 1'b0);
    tick(1);
    check("R2", "comparator flag after edge 3", flag, 1'b1);
    cmp = 1'b0; tick(4);
    sw_clear();
    filt = 1'b1; tick(2);
    cmp = 1'b1; tick(3); cmp = 1'b0; tick(10);
    check("R2", "comparator glitch filtered", flag, 1'b0);
    filt = 1'b0; sel = 1'b0; tick(4);
  endtask

  task automatic t_filter();
    filt = 1'b1; tick(2);
    pin = 1'b1; tick(3); pin = 1'b0; tick(10);
    check("R4", "three-cycle glitch rejected", flag, 1'b0);
    pin = 1'b1;
    tick(6);
    check("R4", "filtered flag after edge 6", flag, 1'b0);
    tick(1);
    check("R4", "filtered flag after edge 7", flag, 1'b1);
    pin = 1'b0; tick(8);
    filt = 1'b0; tick(2);
    sw_clear();
  endtask

  task automatic t_falling();
    rise = 1'b0; tick(2);
    pin = 1'b1; tick(6);
    check("R5", "rising edge ignored in falling mode", flag, 1'b0);
    pin = 1'b0;
    tick(2);
    check("R5", "falling flag after edge 2", flag, 1'b0);
    tick(1);
    check("R5", "falling flag after edge 3", flag, 1'b1);
    tick(2);
    rise = 1'b1;
    sw_clear();
  endtask

  task automatic t_collision();
    pulse_pin_set();
    pin = 1'b1; tick(1);
    wr = 1'b1; wdata = 1'b1; tick(1);
    wr = 1'b0; wdata = 1'b0;
    tick(1);
    check("R10", "edge beats pending clear", flag, 1'b1);
    tick(1);
    check("R10", "flag still set after collision", flag, 1'b1);
    pin = 1'b0; tick(4);
    pin = 1'b1; tick(2);
    ack = 1'b1; tick(1); ack = 1'b0;
    check("R10", "edge beats ack", flag, 1'b1);
    pin = 1'b0; tick(3);
    sw_clear();
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_pin_latency();
    t_sticky_clear();
    t_ack();
    t_irq();
    t_cmp_source();
    t_filter();
    t_falling();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule